// File: doc/BRIEF.md
# Vector Prefix Predicate Mask Generator

This block looks at the 32-bit prefix word that comes before a 64-bit instruction. It decides whether the word marks a vector operation. It then gathers a 24-bit remapped field from non-adjacent prefix bits, and turns the 4-bit predicate code at the head of that field into one enable bit for each of `NELEM` vector elements. The code selects one of three sources:

- a test against the low bits of one of three integer registers;
- a test against one flag of each of `NELEM` condition fields;
- a fixed "all enabled" or "reserved, trap" result.

Each test has a normal form and an inverted form. The 20 remapped bits that follow the code are not interpreted. They travel alongside the result.

Prefixes enter on a valid/ready stream. Results leave on a second valid/ready stream one cycle after acceptance, from a single register stage.

Back-pressure rules:
- A prefix is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, every output holds its value.

Instruction fetch, suffix decode, register-file reads and element execution lie outside this block.

Top module: `vpfx_mask_gen`

## Requirements
- R1: Prefix bits are numbered MSB-first, so prefix bit k is `pfx[31-k]`. `is_vec` is 1 only when prefix bits 0:5 equal 1 and prefix bits 7 and 9 are both 1.
- R2: The remapped field takes bit 6, then bit 8, then bits 10 through 31 of the prefix, with bit 6 as its MSB. The predicate code is its first 4 bits, which are prefix bits {6,8,10,11}, with bit 6 as the code's MSB. `rm_tail` carries its last 20 bits unchanged, which are prefix bits 12:31, equal to `pfx[19:0]`.
- R3: Code 0000 on a vector prefix sets `trap` and forces `elem_en` to all zeros.
- R4: Code 0001 enables every element and does not trap.
- R5: Codes 0010/0011 enable element i when bit i of `reg_r3` is 1 or 0 respectively. Codes 0100/0101 do the same with `reg_r10`, and codes 0110/0111 with `reg_r30`.
- R6: Condition field i sits at `cr_fld[4*i+3:4*i]`, with flag bits LT=3, GT=2, EQ=1, SO=0. Code 1000/1001 enables element i when LT is set or clear respectively. GT uses 1010/1011, EQ uses 1100/1101, and SO uses 1110/1111, in the same set/clear order.
- R7: A prefix that is not a vector prefix gives `elem_en` all ones, `trap` 0 and `is_vec` 0, whatever its code bits hold.
- R8: Results appear on the outputs one cycle after acceptance, with `out_valid` high. `in_ready` is low while a result is held with `out_ready` low, and held outputs stay stable. With `out_ready` high and no new input, `out_valid` drops after one cycle.
- R9: A synchronous active-high `rst` clears `out_valid`, `elem_en`, `is_vec`, `trap` and `rm_tail` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Prefix word is presented |
| in_ready | output | 1 | Block can accept a prefix this cycle |
| pfx | input | 32 | Prefix word; prefix bit 0 is `pfx[31]` |
| reg_r3 | input | NELEM | Low bits of register 3 |
| reg_r10 | input | NELEM | Low bits of register 10 |
| reg_r30 | input | NELEM | Low bits of register 30 |
| cr_fld | input | 4*NELEM | Condition fields 6..6+NELEM-1, field i at bits 4i+3:4i |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| elem_en | output | NELEM | Per-element enable vector |
| is_vec | output | 1 | Accepted prefix was a vector prefix |
| trap | output | 1 | Reserved predicate code seen |
| rm_tail | output | 20 | Uninterpreted remapped bits |

## Verification
The result register has only one stage. A wrong code decode, a misplaced remap bit or a bad condition-field index therefore shows on `elem_en`, `trap` or `rm_tail` in the cycle right after the prefix is accepted. Each predicate code is driven with register and flag values that differ element by element, so a swapped source or a missing inversion changes at least one bit. A fault in the handshake state shows as an output that changes, or an `in_ready` that stays high, during the first stalled cycle.

// File: rtl/vpfx_pkg.sv
`timescale 1ns/1ps
package vpfx_pkg;
  localparam int PFX_W   = 32;
  localparam int CODE_W  = 4;
  localparam int TAIL_W  = 20;
  localparam int FLAG_W  = 4;
  localparam logic [5:0] VEC_OPCODE = 6'd1;

  localparam logic [CODE_W-1:0] PC_RESERVED = 4'b0000;
  localparam logic [CODE_W-1:0] PC_ALWAYS   = 4'b0001;

  // Position of each flag inside a condition field.
  localparam int FLAG_LT = 3;
  localparam int FLAG_GT = 2;
  localparam int FLAG_EQ = 1;
  localparam int FLAG_SO = 0;
endpackage

// File: rtl/vpfx_field_gather.sv
`timescale 1ns/1ps
module vpfx_field_gather
  import vpfx_pkg::*;
(
  input  logic [PFX_W-1:0]  pfx,
  output logic              is_vec,
  output logic [CODE_W-1:0] code,
  output logic [TAIL_W-1:0] tail
);
  // Prefix bit k lives at pfx[31-k].
  assign is_vec = (pfx[31:26] == VEC_OPCODE) && pfx[24] && pfx[22];
  // Code = prefix bits 6, 8, 10, 11.
  assign code   = {pfx[25], pfx[23], pfx[21], pfx[20]};
  // Remaining remapped bits = prefix bits 12..31.
  assign tail   = pfx[19:0];
endmodule

// File: rtl/vpfx_mask_decode.sv
`timescale 1ns/1ps
module vpfx_mask_decode
  import vpfx_pkg::*;
#(
  parameter int NELEM = 8
) (
  input  logic [CODE_W-1:0]       code,
  input  logic [NELEM-1:0]        src_a,
  input  logic [NELEM-1:0]        src_b,
  input  logic [NELEM-1:0]        src_c,
  input  logic [FLAG_W*NELEM-1:0] flags,
  output logic [NELEM-1:0]        en,
  output logic                    trap
);
  logic [NELEM-1:0] flag_pick;
  logic [NELEM-1:0] reg_pick;
  logic [NELEM-1:0] raw;

  // Per element: choose one flag of that element's condition field.
  for (genvar i = 0; i < NELEM; i++) begin : g_flag
    logic [FLAG_W-1:0] fld;
    assign fld = flags[FLAG_W*i +: FLAG_W];
    assign flag_pick[i] = (code[2:1] == 2'b00) ? fld[FLAG_LT] :
                          (code[2:1] == 2'b01) ? fld[FLAG_GT] :
                          (code[2:1] == 2'b10) ? fld[FLAG_EQ] :
                                                 fld[FLAG_SO];
  end

  always_comb begin
    case (code[2:1])
      2'b01:   reg_pick = src_a;
      2'b10:   reg_pick = src_b;
      2'b11:   reg_pick = src_c;
      default: reg_pick = '0;
    endcase
  end

  assign raw = code[3] ? flag_pick : reg_pick;

  always_comb begin
    trap = 1'b0;
    if (code == PC_RESERVED) begin
      trap = 1'b1;
      en   = '0;
    end else if (code == PC_ALWAYS) begin
      en = '1;
    end else begin
      en = raw ^ {NELEM{code[0]}};
    end
  end
endmodule

// File: rtl/vpfx_out_stage.sv
`timescale 1ns/1ps
module vpfx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/vpfx_mask_gen.sv
`timescale 1ns/1ps
module vpfx_mask_gen
  import vpfx_pkg::*;
#(
  parameter int NELEM = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PFX_W-1:0]        pfx,
  input  logic [NELEM-1:0]        reg_r3,
  input  logic [NELEM-1:0]        reg_r10,
  input  logic [NELEM-1:0]        reg_r30,
  input  logic [FLAG_W*NELEM-1:0] cr_fld,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NELEM-1:0]        elem_en,
  output logic                    is_vec,
  output logic                    trap,
  output logic [TAIL_W-1:0]       rm_tail
);
  localparam int PAY_W = NELEM + 2 + TAIL_W;

  logic              g_vec;
  logic [CODE_W-1:0] g_code;
  logic [TAIL_W-1:0] g_tail;
  logic [NELEM-1:0]  d_en;
  logic              d_trap;
  logic [NELEM-1:0]  n_en;
  logic              n_trap;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  vpfx_field_gather u_gather (
    .pfx    (pfx),
    .is_vec (g_vec),
    .code   (g_code),
    .tail   (g_tail)
  );

  vpfx_mask_decode #(.NELEM(NELEM)) u_decode (
    .code  (g_code),
    .src_a (reg_r3),
    .src_b (reg_r10),
    .src_c (reg_r30),
    .flags (cr_fld),
    .en    (d_en),
    .trap  (d_trap)
  );

  // A non-vector prefix runs unmasked and never traps.
  assign n_en   = g_vec ? d_en : '1;
  assign n_trap = g_vec & d_trap;
  assign pay_in = {g_vec, n_trap, g_tail, n_en};

  vpfx_out_stage #(.W(PAY_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign {is_vec, trap, rm_tail, elem_en} = pay_out;
endmodule

// File: rtl/vpfx_mask_chk.sv
`timescale 1ns/1ps
module vpfx_mask_chk #(
  parameter int NELEM = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      pfx,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NELEM-1:0] elem_en,
  input logic             is_vec,
  input logic             trap,
  input logic [19:0]      rm_tail
);
  a_r3_trap_blanks: assert property (@(posedge clk) disable iff (rst)
    out_valid && trap |-> elem_en == '0);

  a_r3_trap_only_vec: assert property (@(posedge clk) disable iff (rst)
    out_valid && trap |-> is_vec);

  a_r7_nonvec_open: assert property (@(posedge clk) disable iff (rst)
    out_valid && !is_vec |-> (&elem_en) && !trap);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(elem_en) && $stable(trap)
                                && $stable(is_vec) && $stable(rm_tail));

  a_r8_drain: assert property (@(posedge clk) disable iff (rst)
    out_ready && !in_valid |=> !out_valid);

  a_r2_tail_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> rm_tail == $past(pfx[19:0]));
endmodule

bind vpfx_mask_gen vpfx_mask_chk #(.NELEM(NELEM)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pfx       (pfx),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .elem_en   (elem_en),
  .is_vec    (is_vec),
  .trap      (trap),
  .rm_tail   (rm_tail)
);

// File: tb/tb_vpfx_mask_gen.sv
`timescale 1ns/1ps
module tb_vpfx_mask_gen;
  localparam int NELEM = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      pfx = '0;
  logic [NELEM-1:0] reg_r3 = 8'hA5;
  logic [NELEM-1:0] reg_r10 = 8'h3C;
  logic [NELEM-1:0] reg_r30 = 8'h81;
  logic [4*NELEM-1:0] cr_fld = 32'h9F3C_6A15;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [NELEM-1:0] elem_en;
  logic             is_vec;
  logic             trap;
  logic [19:0]      rm_tail;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vpfx_mask_gen #(.NELEM(NELEM)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .pfx(pfx), .reg_r3(reg_r3), .reg_r10(reg_r10), .reg_r30(reg_r30),
    .cr_fld(cr_fld), .out_valid(out_valid), .out_ready(out_ready),
    .elem_en(elem_en), .is_vec(is_vec), .trap(trap), .rm_tail(rm_tail)
  );

  function automatic logic [31:0] mk_vec(input logic [3:0] code, input logic [19:0] tl);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'd1;   // prefix bits 0:5
    w[25] = code[3];   // bit 6
    w[24] = 1'b1;      // bit 7
    w[23] = code[2];   // bit 8
    w[22] = 1'b1;      // bit 9
    w[21] = code[1];   // bit 10
    w[20] = code[0];   // bit 11
    w[19:0] = tl;
    return w;
  endfunction

  function automatic logic [NELEM-1:0] model_en(input logic [3:0] code);
    logic [NELEM-1:0] e;
    for (int i = 0; i < NELEM; i++) begin
      logic [3:0] f;
      f = cr_fld[4*i +: 4];
      case (code)
        4'h0: e[i] = 1'b0;
        4'h1: e[i] = 1'b1;
        4'h2: e[i] = reg_r3[i];
        4'h3: e[i] = !reg_r3[i];
        4'h4: e[i] = reg_r10[i];
        4'h5: e[i] = !reg_r10[i];
        4'h6: e[i] = reg_r30[i];
        4'h7: e[i] = !reg_r30[i];
        4'h8: e[i] = f[3];
        4'h9: e[i] = !f[3];
        4'hA: e[i] = f[2];
        4'hB: e[i] = !f[2];
        4'hC: e[i] = f[1];
        4'hD: e[i] = !f[1];
        4'hE: e[i] = f[0];
        default: e[i] = !f[0];
      endcase
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    pfx = w;
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "out_valid", {31'b0, out_valid}, 32'd0);
    chk("R9", "elem_en", {24'b0, elem_en}, 32'd0);
    chk("R9", "flags", {30'b0, is_vec, trap}, 32'd0);
    chk("R9", "rm_tail", {12'b0, rm_tail}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_all_codes(input logic [19:0] tl);
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code;
      string rq;
      code = c[3:0];
      rq = (c == 0) ? "R3" : (c == 1) ? "R4" : (c < 8) ? "R5" : "R6";
      send(mk_vec(code, tl));
      chk(rq, "elem_en", {24'b0, elem_en}, {24'b0, model_en(code)});
      chk(rq, "trap", {31'b0, trap}, {31'b0, (c == 0)});
      chk("R1", "is_vec", {31'b0, is_vec}, 32'd1);
      chk("R8", "out_valid", {31'b0, out_valid}, 32'd1);
      chk("R2", "rm_tail", {12'b0, rm_tail}, {12'b0, tl});
    end
  endtask

  task automatic t_nonvec;
    logic [31:0] w [3];
    w[0] = mk_vec(4'h0, 20'h12345) ^ 32'h0400_0000; // opcode changed
    w[1] = mk_vec(4'h0, 20'h0F0F0) & ~32'h0100_0000; // bit 7 clear
    w[2] = mk_vec(4'h2, 20'hABCDE) & ~32'h0040_0000; // bit 9 clear
    for (int k = 0; k < 3; k++) begin
      send(w[k]);
      chk("R7", "elem_en", {24'b0, elem_en}, 32'h0000_00FF);
      chk("R7", "trap", {31'b0, trap}, 32'd0);
      chk("R1", "is_vec", {31'b0, is_vec}, 32'd0);
    end
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    pfx = mk_vec(4'h2, 20'h11111);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    pfx = mk_vec(4'h0, 20'h22222);
    chk("R8", "in_ready stalled", {31'b0, in_ready}, 32'd0);
    chk("R8", "first elem_en", {24'b0, elem_en}, {24'b0, reg_r3});
    @(posedge clk);
    @(negedge clk);
    chk("R8", "held elem_en", {24'b0, elem_en}, {24'b0, reg_r3});
    chk("R8", "held tail", {12'b0, rm_tail}, 32'h0001_1111);
    chk("R8", "held trap", {31'b0, trap}, 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", "second trap", {31'b0, trap}, 32'd1);
    chk("R3", "second elem_en", {24'b0, elem_en}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8", "drained out_valid", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_all_codes(20'h5A3C1);
    reg_r3 = 8'h0F; reg_r10 = 8'hF0; reg_r30 = 8'h66;
    cr_fld = 32'h1248_EDB7;
    t_all_codes(20'hA5C3E);
    t_nonvec();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule